// File: doc/BRIEF.md
# PLL Loop Bandwidth Mode Controller

This block picks the loop-bandwidth code that a clock-translation loop should use at any moment. It looks at the configured operating state, a synthesizer-mode bit, an acquisition-enable bit and a lock indicator. From these it chooses one of two programmable 4-bit codes: a wide fast-lock code used while acquiring, and a narrow code used once locked. In synthesizer free-run operation it replaces both with a fixed wide-bandwidth code. The loop filter, the phase detector and the lock detector sit outside the block. The lock indicator arrives asynchronously and is resynchronized inside.

Programmable codes 0 to 14 stand for the loop bandwidths in ascending order: 0.2, 0.4, 0.8, 1.6, 3.2, 6.4, 12, 25, 50, 100, 200, 400 and 800 Hz, then 1.6 kHz and 6.4 kHz. Code 15 is reserved for the fixed synthesizer bandwidth of roughly 200 kHz.

The state field is encoded as 00 automatic, 01 free-run, 10 forced normal and 11 holdover. A four-state machine reports the loop mode as 00 ACQUIRE, 01 LOCKED, 10 SYNTH and 11 HOLD. Its transitions are evaluated from every state with the same priority:
- to SYNTH when the synthesizer bit is set and the state field is free-run;
- otherwise to HOLD when the field is holdover, or free-run without the synthesizer bit;
- otherwise to ACQUIRE when acquisition is enabled and the synchronized lock is low;
- otherwise to LOCKED.

This gives the named transitions ACQUIRE→LOCKED on lock, LOCKED→ACQUIRE on lock loss, any→SYNTH, any→HOLD, and HOLD/SYNTH→ACQUIRE or LOCKED on return to a tracking state.

Top module: `pll_bw_ctrl`

## Requirements
- R1: Reset is synchronous and active low. At each clock edge where reset is low, the code output loads the (limited) acquisition code if acquisition is enabled, otherwise the (limited) locked code. The mode becomes ACQUIRE (00) or LOCKED (01) to match, and the synthesizer flag and change strobe clear. The synthesizer bit and the state field have no effect during reset.
- R2: In automatic (00) or forced-normal (10) state, with acquisition enabled and the synchronized lock low, the output is the acquisition code and the mode is ACQUIRE (00).
- R3: In automatic or forced-normal state, with the synchronized lock high or acquisition disabled, the output is the locked code and the mode is LOCKED (01).
- R4: With the synthesizer bit high and the state field free-run (01), the output is 15, the synthesizer flag is high and the mode is SYNTH (10). The lock input and both programmable codes have no effect on the output, which shows no change strobe while they toggle.
- R5: In holdover (11), or in free-run with the synthesizer bit low, the output keeps its previous code and the mode is HOLD (11).
- R6: A programmable code input of 15 is limited to 14, so that code 15 appears only through SYNTH or by holding it.
- R7: A change on a direct input shows at the outputs after one clock edge. A change on the lock input shows after three edges: two synchronizer stages plus the output register.
- R8: The change strobe is high for exactly the one cycle in which the code output differs from its value in the previous cycle, and low otherwise.
- R9: With the synthesizer bit high, a state field other than free-run gives normal tracking, exactly as R2 and R3 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| synth_mode_i | input | 1 | Synthesizer-mode bit |
| state_i | input | 2 | Operating state: 00 automatic, 01 free-run, 10 forced normal, 11 holdover |
| acq_en_i | input | 1 | Enables the acquisition bandwidth while unlocked |
| lock_async_i | input | 1 | Asynchronous lock indicator |
| acq_bw_i | input | 4 | Acquisition bandwidth code, 0 to 14 |
| lck_bw_i | input | 4 | Locked bandwidth code, 0 to 14 |
| bw_code_o | output | 4 | Registered active bandwidth code (15 is the fixed synthesizer bandwidth) |
| synth_bw_o | output | 1 | High while the mode is SYNTH |
| mode_o | output | 2 | Loop mode: 00 ACQUIRE, 01 LOCKED, 10 SYNTH, 11 HOLD |
| bw_chg_o | output | 1 | One-cycle strobe when the code output changes |

## Verification
The code, flag, mode and strobe outputs all come from one register stage. A change on a direct input is therefore due one edge later, and the strobe rises in that same cycle. A lock change travels through two synchronizer flops first, so it is due on the third edge. The bench drives inputs on falling edges and samples on the falling edge after the counted number of rising edges. Each table vector waits three edges so that both latencies have settled. Directed tests then sample after one, two and three edges to pin down each latency exactly.

// File: rtl/pll_bw_pkg.sv
package pll_bw_pkg;
    localparam int BW_W = 4;
    localparam logic [BW_W-1:0] BW_SYNTH    = '1;
    localparam logic [BW_W-1:0] BW_MAX_PROG = BW_SYNTH - 1'b1;

    typedef enum logic [1:0] {
        CFG_AUTO   = 2'b00,
        CFG_FREE   = 2'b01,
        CFG_FORCED = 2'b10,
        CFG_HOLD   = 2'b11
    } cfg_state_e;

    typedef enum logic [1:0] {
        LM_ACQ   = 2'b00,
        LM_LOCK  = 2'b01,
        LM_SYNTH = 2'b10,
        LM_HOLD  = 2'b11
    } loop_mode_e;

    function automatic logic [BW_W-1:0] bw_limit(input logic [BW_W-1:0] c);
        return (c > BW_MAX_PROG) ? BW_MAX_PROG : c;
    endfunction
endpackage

// File: rtl/pll_bw_sync.sv
module pll_bw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_bw_fsm.sv
module pll_bw_fsm
    import pll_bw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       synth_i,
    input  cfg_state_e cfg_i,
    input  logic       acq_en_i,
    input  logic       lock_i,
    output loop_mode_e mode_o,
    output loop_mode_e next_o
);
    loop_mode_e state_q, state_d;

    logic go_synth, go_hold, want_acq;
    assign go_synth = synth_i && (cfg_i == CFG_FREE);
    assign go_hold  = (cfg_i == CFG_HOLD) || ((cfg_i == CFG_FREE) && !synth_i);
    assign want_acq = acq_en_i && !lock_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_ACQ: begin
                if (go_synth)      state_d = LM_SYNTH;
                else if (go_hold)  state_d = LM_HOLD;
                else if (!want_acq) state_d = LM_LOCK;
                else               state_d = LM_ACQ;
            end
            LM_LOCK: begin
                if (go_synth)      state_d = LM_SYNTH;
                else if (go_hold)  state_d = LM_HOLD;
                else if (want_acq) state_d = LM_ACQ;
                else               state_d = LM_LOCK;
            end
            LM_SYNTH: begin
                if (go_synth)      state_d = LM_SYNTH;
                else if (go_hold)  state_d = LM_HOLD;
                else if (want_acq) state_d = LM_ACQ;
                else               state_d = LM_LOCK;
            end
            LM_HOLD: begin
                if (go_synth)      state_d = LM_SYNTH;
                else if (go_hold)  state_d = LM_HOLD;
                else if (want_acq) state_d = LM_ACQ;
                else               state_d = LM_LOCK;
            end
            default:               state_d = LM_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= acq_en_i ? LM_ACQ : LM_LOCK;
        else        state_q <= state_d;
    end

    assign mode_o = state_q;
    assign next_o = state_d;
endmodule

// File: rtl/pll_bw_code.sv
module pll_bw_code
    import pll_bw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  loop_mode_e      next_i,
    input  logic            acq_en_i,
    input  logic [BW_W-1:0] acq_bw_i,
    input  logic [BW_W-1:0] lck_bw_i,
    output logic [BW_W-1:0] code_o,
    output logic            chg_o,
    output logic            synth_o
);
    logic [BW_W-1:0] code_q, code_d, acq_lim, lck_lim;
    logic            chg_q, synth_q;

    assign acq_lim = bw_limit(acq_bw_i);
    assign lck_lim = bw_limit(lck_bw_i);

    always_comb begin
        unique case (next_i)
            LM_ACQ:   code_d = acq_lim;
            LM_LOCK:  code_d = lck_lim;
            LM_SYNTH: code_d = BW_SYNTH;
            LM_HOLD:  code_d = code_q;
            default:  code_d = code_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= acq_en_i ? acq_lim : lck_lim;
            chg_q   <= 1'b0;
            synth_q <= 1'b0;
        end else begin
            code_q  <= code_d;
            chg_q   <= (code_d != code_q);
            synth_q <= (next_i == LM_SYNTH);
        end
    end

    assign code_o  = code_q;
    assign chg_o   = chg_q;
    assign synth_o = synth_q;
endmodule

// File: rtl/pll_bw_ctrl.sv
module pll_bw_ctrl
    import pll_bw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        synth_mode_i,
    input  logic [1:0]  state_i,
    input  logic        acq_en_i,
    input  logic        lock_async_i,
    input  logic [3:0]  acq_bw_i,
    input  logic [3:0]  lck_bw_i,
    output logic [3:0]  bw_code_o,
    output logic        synth_bw_o,
    output logic [1:0]  mode_o,
    output logic        bw_chg_o
);
    logic       lock_s;
    loop_mode_e mode_q, mode_d;

    pll_bw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lock_async_i),
        .q_o   (lock_s)
    );

    pll_bw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .synth_i  (synth_mode_i),
        .cfg_i    (cfg_state_e'(state_i)),
        .acq_en_i (acq_en_i),
        .lock_i   (lock_s),
        .mode_o   (mode_q),
        .next_o   (mode_d)
    );

    pll_bw_code u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_i   (mode_d),
        .acq_en_i (acq_en_i),
        .acq_bw_i (acq_bw_i),
        .lck_bw_i (lck_bw_i),
        .code_o   (bw_code_o),
        .chg_o    (bw_chg_o),
        .synth_o  (synth_bw_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/pll_bw_ctrl_chk.sv
module pll_bw_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       synth_mode_i,
    input logic [1:0] state_i,
    input logic [3:0] bw_code_o,
    input logic       synth_bw_o,
    input logic [1:0] mode_o,
    input logic       bw_chg_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4: the fixed code comes with the flag
    assert_synth_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        synth_bw_o |-> (bw_code_o == 4'd15 && mode_o == 2'b10));

    // R4: SYNTH entered only from the synth/free-run request one edge earlier
    assert_synth_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_o == 2'b10) |-> $past(synth_mode_i && state_i == 2'b01));

    // R5: holdover keeps the code
    assert_hold_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_o == 2'b11) |-> (bw_code_o == $past(bw_code_o)));

    // R6: code 15 only in SYNTH or HOLD
    assert_no_prog15_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_code_o == 4'd15) |-> (mode_o == 2'b10 || mode_o == 2'b11));

    // R8: strobe marks exactly the code changes
    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (bw_chg_o == (bw_code_o != $past(bw_code_o))));
endmodule

bind pll_bw_ctrl pll_bw_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .synth_mode_i (synth_mode_i),
    .state_i      (state_i),
    .bw_code_o    (bw_code_o),
    .synth_bw_o   (synth_bw_o),
    .mode_o       (mode_o),
    .bw_chg_o     (bw_chg_o)
);

// File: tb/tb_pll_bw_ctrl.sv
module tb_pll_bw_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       synth_mode_i;
    logic [1:0] state_i;
    logic       acq_en_i;
    logic       lock_async_i;
    logic [3:0] acq_bw_i;
    logic [3:0] lck_bw_i;
    logic [3:0] bw_code_o;
    logic       synth_bw_o;
    logic [1:0] mode_o;
    logic       bw_chg_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    pll_bw_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .synth_mode_i (synth_mode_i),
        .state_i      (state_i),
        .acq_en_i     (acq_en_i),
        .lock_async_i (lock_async_i),
        .acq_bw_i     (acq_bw_i),
        .lck_bw_i     (lck_bw_i),
        .bw_code_o    (bw_code_o),
        .synth_bw_o   (synth_bw_o),
        .mode_o       (mode_o),
        .bw_chg_o     (bw_chg_o)
    );

    // {synth, state[2], acq_en, lock, acq[4], lck[4], exp_code[4], exp_synth, exp_mode[2]}
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'b00, 1'b1, 1'b0, 4'd3,  4'd9,  4'd3,  1'b0, 2'b00}, // R2
        {1'b0, 2'b00, 1'b1, 1'b1, 4'd3,  4'd9,  4'd9,  1'b0, 2'b01}, // R3
        {1'b0, 2'b00, 1'b0, 1'b0, 4'd3,  4'd9,  4'd9,  1'b0, 2'b01}, // R3
        {1'b0, 2'b10, 1'b1, 1'b0, 4'd5,  4'd7,  4'd5,  1'b0, 2'b00}, // R2
        {1'b0, 2'b10, 1'b1, 1'b1, 4'd5,  4'd7,  4'd7,  1'b0, 2'b01}, // R3
        {1'b1, 2'b01, 1'b1, 1'b0, 4'd5,  4'd7,  4'd15, 1'b1, 2'b10}, // R4
        {1'b1, 2'b01, 1'b0, 1'b1, 4'd2,  4'd4,  4'd15, 1'b1, 2'b10}, // R4
        {1'b0, 2'b11, 1'b1, 1'b0, 4'd2,  4'd4,  4'd15, 1'b0, 2'b11}, // R5
        {1'b0, 2'b00, 1'b1, 1'b0, 4'd15, 4'd4,  4'd14, 1'b0, 2'b00}, // R6
        {1'b0, 2'b11, 1'b0, 1'b1, 4'd1,  4'd2,  4'd14, 1'b0, 2'b11}, // R5
        {1'b0, 2'b01, 1'b1, 1'b1, 4'd1,  4'd2,  4'd14, 1'b0, 2'b11}, // R5
        {1'b1, 2'b00, 1'b1, 1'b1, 4'd1,  4'd12, 4'd12, 1'b0, 2'b01}, // R9
        {1'b0, 2'b00, 1'b0, 1'b1, 4'd3,  4'd15, 4'd14, 1'b0, 2'b01}  // R6
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        synth_mode_i = 1'b1;
        state_i = 2'b01;
        acq_en_i = 1'b1;
        lock_async_i = 1'b0;
        acq_bw_i = 4'd3;
        lck_bw_i = 4'd9;
        step(3);
        // R1: reset ignores synth/free-run, loads acquisition code
        chk("R1 code", bw_code_o, 3);
        chk("R1 mode", mode_o, 0);
        chk("R1 synth", synth_bw_o, 0);
        chk("R1 strobe", bw_chg_o, 0);
        acq_en_i = 1'b0;
        step(1);
        chk("R1 code acq off", bw_code_o, 9);
        chk("R1 mode acq off", mode_o, 1);
        acq_en_i = 1'b1;
        state_i = 2'b00;
        synth_mode_i = 1'b0;
        step(1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            synth_mode_i = VEC[i][19];
            state_i      = VEC[i][18:17];
            acq_en_i     = VEC[i][16];
            lock_async_i = VEC[i][15];
            acq_bw_i     = VEC[i][14:11];
            lck_bw_i     = VEC[i][10:7];
            step(3);
            chk($sformatf("vec%0d code (R2 R3 R4 R5 R6 R9)", i), bw_code_o, VEC[i][6:3]);
            chk($sformatf("vec%0d synth flag", i), synth_bw_o, VEC[i][2]);
            chk($sformatf("vec%0d mode", i), mode_o, VEC[i][1:0]);
        end

        // R7 / R8: direct input latency and strobe
        synth_mode_i = 1'b0; state_i = 2'b00; acq_en_i = 1'b0;
        lock_async_i = 1'b0; lck_bw_i = 4'd9; acq_bw_i = 4'd3;
        step(3);
        chk("R7 settle", bw_code_o, 9);
        chk("R8 quiet", bw_chg_o, 0);
        lck_bw_i = 4'd10;
        step(1);
        chk("R7 one edge", bw_code_o, 10);
        chk("R8 strobe high", bw_chg_o, 1);
        step(1);
        chk("R8 strobe one cycle", bw_chg_o, 0);

        // R7: lock path takes three edges
        acq_en_i = 1'b1;
        step(3);
        chk("R2 acq before lock", bw_code_o, 3);
        lock_async_i = 1'b1;
        step(1);
        chk("R7 lock edge1", bw_code_o, 3);
        step(1);
        chk("R7 lock edge2", bw_code_o, 3);
        chk("R8 no strobe", bw_chg_o, 0);
        step(1);
        chk("R7 lock edge3", bw_code_o, 10);
        chk("R8 strobe on lock", bw_chg_o, 1);

        // R4: lock and programmable codes ignored in synth free-run
        synth_mode_i = 1'b1; state_i = 2'b01;
        step(1);
        chk("R4 enter synth", bw_code_o, 15);
        step(1);
        for (int k = 0; k < 4; k++) begin
            lock_async_i = ~lock_async_i;
            acq_bw_i = 4'(k + 1);
            lck_bw_i = 4'(k + 6);
            step(1);
            chk("R4 synth code held", bw_code_o, 15);
            chk("R4 synth no strobe", bw_chg_o, 0);
        end

        // R5: leaving synth into holdover keeps 15, then back to tracking
        synth_mode_i = 1'b0; state_i = 2'b11;
        step(1);
        chk("R5 hold mode", mode_o, 3);
        chk("R5 hold code", bw_code_o, 15);
        chk("R5 hold flag", synth_bw_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule